// File: doc/BRIEF.md
# Synchronous Audio Serial Frame Receiver

This block turns one serial audio data line into parallel words and queues them in a small receive FIFO. It has no bit clock or frame sync of its own. It samples the data line and the frame sync on a bit-clock strobe that belongs to a companion transmitter, and it takes the transmitter's framing settings: sync polarity, early sync, word length, words per frame and bit order. A slot mask selects which words of a frame are kept.

A consumer drains the FIFO through a show-ahead read port. A request output rises while the FIFO holds more words than a programmable watermark. If a word completes while the FIFO is full, the word is lost and a sticky overflow flag is set. Disabling the receiver clears that flag. After the receiver is enabled it ignores everything until the next frame sync edge, so words always line up with frame boundaries.

Top module: `sync_audio_rx`

## Requirements
- R1: After reset `empty` is 1, and `level`, `fifo_req` and `overflow` are 0.
- R2: The line is sampled only on cycles where `bclk_tick` and `tx_en` are both high. The sync is active when `fs_in` differs from `sync_inv`. A frame starts on a sampled change of the sync from inactive to active while `rx_en` is high.
- R3: With `sync_early` low, the bit sampled together with the sync edge is bit 0 of slot 0. With `sync_early` high, bit 0 of slot 0 is the bit sampled on the next tick.
- R4: With `msb_first` high, the first received bit of a word lands at index `word_len`-1 and later bits at descending indices. With it low, the first bit lands at index 0 and later bits at ascending indices. Bits at index `word_len` and above read as 0.
- R5: A frame holds `frame_words` words of `word_len` bits each. Bits after the last word are ignored until the next sync edge.
- R6: Bit i of `slot_mask` set means that slot i, counted from 0 after the sync, is never written to the FIFO.
- R7: `fifo_req` is high exactly while `level` is greater than `watermark`.
- R8: A word that completes while `level` equals the FIFO depth is dropped and sets `overflow`. `overflow` stays set while `rx_en` is high and clears once `rx_en` is low.
- R9: When `rx_en` rises during a frame, that partial frame produces no words. Capture begins at the next sync edge.
- R10: Enable ordering: the receiver is enabled before the transmitter clock starts, and `rx_en` falls only while `tx_en` is low. Under that ordering, the first frame after start-up is captured complete.
- R11: Words are read in arrival order. `rd_data` shows the oldest word, and `pop` advances it. A `pop` while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable; gates the shared bit clock |
| bclk_tick | input | 1 | One-cycle strobe per shared bit clock |
| fs_in | input | 1 | Shared frame sync line |
| sd_in | input | 1 | Serial data line |
| sync_inv | input | 1 | Sync is active low when set |
| sync_early | input | 1 | Sync precedes the first data bit by one bit |
| msb_first | input | 1 | Bit order select |
| word_len | input | 6 | Bits per word, 1 to MAXW |
| frame_words | input | 4 | Words per frame, 1 to SLOTS |
| slot_mask | input | 8 | Per-slot discard mask |
| watermark | input | 4 | Request threshold |
| pop | input | 1 | Read strobe |
| rd_data | output | 32 | Oldest FIFO word |
| level | output | 4 | FIFO occupancy |
| empty | output | 1 | FIFO holds no word |
| fifo_req | output | 1 | Level above watermark |
| overflow | output | 1 | Sticky word-drop flag |

## Verification
A wrong bit or slot counter appears in the data at once: every word after it in the same frame comes out shifted or rotated, or lands in the wrong slot. The bench sees this at the first pop after that frame. A wrong alignment state, such as a stale pending early flag or a missed sync edge, appears within one frame as one extra bit, a missing word, or words from a partial frame. FIFO pointer or count errors show in `level`, in `fifo_req` against the watermark, and in the word order at the next drain. A lost overflow flag shows on the first check after a frame that overfills the FIFO.

// File: rtl/sync_audio_rx.sv
module sync_audio_rx #(
  parameter int MAXW  = 32,
  parameter int SLOTS = 8,
  parameter int DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_en,
  input  logic                             tx_en,
  input  logic                             bclk_tick,
  input  logic                             fs_in,
  input  logic                             sd_in,
  input  logic                             sync_inv,
  input  logic                             sync_early,
  input  logic                             msb_first,
  input  logic [$clog2(MAXW+1)-1:0]        word_len,
  input  logic [$clog2(SLOTS+1)-1:0]       frame_words,
  input  logic [SLOTS-1:0]                 slot_mask,
  input  logic [$clog2(DEPTH+1)-1:0]       watermark,
  input  logic                             pop,
  output logic [MAXW-1:0]                  rd_data,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic                             empty,
  output logic                             fifo_req,
  output logic                             overflow
);
  localparam int WW = $clog2(MAXW+1);
  localparam int SW = $clog2(SLOTS+1);
  localparam int SI = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic            fs_q, pend, active;
  logic [WW-1:0]   bit_cnt;
  logic [SW-1:0]   slot_cnt;
  logic [MAXW-1:0] acc;

  logic            tick, sync_now, start, begin_w, step, word_done, last_slot, push;
  logic [WW-1:0]   bit_idx, pos;
  logic [SW-1:0]   slot_idx;
  logic [MAXW-1:0] acc_next;

  assign tick      = bclk_tick & tx_en;
  assign sync_now  = fs_in ^ sync_inv;
  assign start     = rx_en & tick & sync_now & ~fs_q;
  assign begin_w   = rx_en & ((start & ~sync_early) | (tick & pend));
  assign step      = rx_en & tick & (begin_w | active);
  assign bit_idx   = begin_w ? '0 : bit_cnt;
  assign slot_idx  = begin_w ? '0 : slot_cnt;
  assign pos       = msb_first ? (word_len - WW'(1) - bit_idx) : bit_idx;
  assign acc_next  = ((bit_idx == '0) ? '0 : acc) | (MAXW'(sd_in) << pos);
  assign word_done = step & (bit_idx == word_len - WW'(1));
  assign last_slot = (slot_idx == frame_words - SW'(1));
  assign push      = word_done & ~slot_mask[slot_idx[SI-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      pend     <= 1'b0;
      active   <= 1'b0;
      bit_cnt  <= '0;
      slot_cnt <= '0;
      acc      <= '0;
    end else begin
      if (tick) fs_q <= sync_now;
      if (!rx_en) begin
        pend   <= 1'b0;
        active <= 1'b0;
      end else begin
        if (start)     pend <= sync_early;
        else if (tick) pend <= 1'b0;
        if (step) begin
          acc <= acc_next;
          if (word_done) begin
            bit_cnt <= '0;
            if (last_slot) active <= 1'b0;
            else begin
              active   <= 1'b1;
              slot_cnt <= slot_idx + SW'(1);
            end
          end else begin
            active   <= 1'b1;
            bit_cnt  <= bit_idx + WW'(1);
            slot_cnt <= slot_idx;
          end
        end
      end
    end
  end

  logic [MAXW-1:0] mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [LW-1:0]   cnt;
  logic            full, wr, rd;

  assign full     = (cnt == LW'(DEPTH));
  assign empty    = (cnt == '0);
  assign wr       = push & ~full;
  assign rd       = pop & ~empty;
  assign rd_data  = mem[rptr];
  assign level    = cnt;
  assign fifo_req = (cnt > watermark);

  always_ff @(posedge clk) if (wr) mem[wptr] <= acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + LW'(wr) - LW'(rd);
      if (!rx_en)           overflow <= 1'b0;
      else if (push & full) overflow <= 1'b1;
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && rx_en) |=> overflow);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && level == LW'(DEPTH) && rx_en) |=> overflow);
  // R10
  en_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> !tx_en);
  // R9
  idle_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (level <= $past(level)));
  // R7
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_req |-> !empty);
endmodule

// File: tb/sim_sync_audio_rx.sv
module sim_sync_audio_rx;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, tx_en = 0, bclk_tick = 0, fs_in = 0, sd_in = 0;
  logic sync_inv = 0, sync_early = 0, msb_first = 1;
  logic [5:0] word_len = 6'd16;
  logic [3:0] frame_words = 4'd2;
  logic [7:0] slot_mask = 8'h00;
  logic [3:0] watermark = 4'd0;
  logic pop = 0;
  logic [31:0] rd_data;
  logic [3:0] level;
  logic empty, fifo_req, overflow;

  sync_audio_rx u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] fr[8];
  bit exp_ovf = 0;
  bit done = 0;

  function automatic logic [31:0] trim(logic [31:0] w, int wl);
    logic [63:0] m;
    m = (64'd1 << wl) - 64'd1;
    return w & m[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(bit act, bit d);
    @(negedge clk);
    bclk_tick = 1; fs_in = act ^ sync_inv; sd_in = d;
    @(negedge clk);
    bclk_tick = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(int synclen, bit model, int en_at);
    int wl, fw, n, e;
    wl = int'(word_len); fw = int'(frame_words); e = sync_early ? 1 : 0;
    repeat (2) tick(0, 1'($urandom));
    n = e + fw * wl;
    for (int t = 0; t < n; t++) begin
      int d;
      bit b;
      if (t == en_at) begin @(negedge clk); rx_en = 1; end
      d = t - e;
      if (d < 0) b = 1'($urandom);
      else b = msb_first ? fr[d / wl][wl - 1 - d % wl] : fr[d / wl][d % wl];
      tick(t < synclen, b);
    end
    repeat (2) tick(0, 1'($urandom));
    if (model)
      for (int s = 0; s < fw; s++)
        if (!slot_mask[s]) begin
          if (exp_q.size() == DEPTH) exp_ovf = 1;
          else exp_q.push_back(trim(fr[s], wl));
        end
  endtask

  task automatic drain(string req);
    check({req, " level"}, 32'(level), 32'(exp_q.size()));
    check("R7 req", 32'(fifo_req), 32'(exp_q.size() > int'(watermark)));
    while (exp_q.size() > 0) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      check({req, " data"}, rd_data, e);
      pop = 1;
      @(negedge clk);
      pop = 0;
    end
    @(negedge clk);
    check("R11 empty after drain", 32'(empty), 32'd1);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 8; i++) fr[i] = $urandom;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(empty), 1);
    check("R1 level", 32'(level), 0);
    check("R1 req", 32'(fifo_req), 0);
    check("R1 ovf", 32'(overflow), 0);

    // R10 receiver first, then transmitter; first frame complete
    rx_en = 1; @(negedge clk); tx_en = 1;
    fill_random();
    word_len = 16; frame_words = 2; slot_mask = 0; msb_first = 1;
    send_frame(1, 1, -1);
    drain("R10 first frame");

    // R3 early sync with word-length sync, LSB first (R4)
    sync_early = 1; msb_first = 0; word_len = 24; frame_words = 3; sync_inv = 1;
    fill_random();
    send_frame(24, 1, -1);
    drain("R3 early R4 lsb");

    // R6 mask slots 1 and 3 of 4
    sync_early = 0; sync_inv = 0; msb_first = 1; word_len = 8; frame_words = 4; slot_mask = 8'h0A;
    fill_random();
    send_frame(1, 1, -1);
    drain("R6 mask");
    slot_mask = 0;

    // R2 no capture while transmitter clock stopped
    tx_en = 0;
    fill_random();
    send_frame(1, 0, -1);
    check("R2 tx off level", 32'(level), 0);
    tx_en = 1;

    // R11 pop on empty ignored
    @(negedge clk); pop = 1; @(negedge clk); pop = 0;
    check("R11 pop empty level", 32'(level), 0);

    // R8 overflow: two full frames of 8 words
    word_len = 8; frame_words = 8; watermark = 7;
    fill_random(); send_frame(1, 1, -1);
    fill_random(); send_frame(1, 1, -1);
    check("R8 ovf set", 32'(overflow), 32'(exp_ovf));
    check("R7 req full", 32'(fifo_req), 1);
    drain("R8 kept words");
    check("R8 ovf sticky", 32'(overflow), 1);
    tx_en = 0; @(negedge clk); rx_en = 0; @(negedge clk); @(negedge clk);
    check("R8 ovf cleared", 32'(overflow), 0);
    exp_ovf = 0;

    // R9 enable mid-frame: partial frame dropped, next frame full
    tx_en = 1; frame_words = 4; word_len = 12; watermark = 2;
    fill_random();
    send_frame(1, 0, 20);
    check("R9 partial dropped", 32'(level), 0);
    fill_random();
    send_frame(1, 1, -1);
    drain("R9 next frame");

    // R5 R4 random configurations
    for (int k = 0; k < 30; k++) begin
      int wl;
      wl = 1 + int'($urandom_range(0, 31));
      word_len = 6'(wl);
      frame_words = 4'($urandom_range(1, 8));
      slot_mask = 8'($urandom);
      msb_first = 1'($urandom);
      sync_early = 1'($urandom);
      sync_inv = 1'($urandom);
      watermark = 4'($urandom_range(0, 7));
      fill_random();
      send_frame(($urandom % 2) ? wl : 1, 1, -1);
      drain("R5 random");
      check("R8 no ovf", 32'(overflow), 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule